// File: doc/BRIEF.md
# MDIO Paged Register Bridge

This block gives a management bus whose registers are only 16 bits wide a path into a 32-bit internal register space. It sits behind a port that already presents decoded management transactions (PHY address, register number, direction, write data) and answers only the transactions aimed at its own fixed PHY address. Serial framing and indirect extended-register access are handled elsewhere.

A 10-bit page register forms the top of the internal byte address. Sixteen low registers each pick one 32-bit word inside the current page and carry that word's lower half. A single shared register carries the upper half of whichever word was touched last. To write a word, software loads the page, writes the lower half to the low register that picks the word, then writes the upper half to the shared register. That last write launches one internal bus write. To read a word, software loads the page and reads the low register. That read launches the internal bus read and keeps the whole word. The following read of the shared register returns the kept upper half, so both halves always come from one access.

Top module: `mdio_page_bridge`

## Requirements
- R1: Only transactions with PHY address 31 have any effect. Transactions with any other PHY address cause no bus strobe and no read response, and they leave the page and word select unchanged.
- R2: A write to register 31 loads the page from bits 9:0 of the write data and ignores bits 15:10. The page drives internal address bits 15:6. A read of register 31 returns the page, zero-extended, one cycle after the transaction.
- R3: A write to a low register (0 to 15) stores the data as the pending lower half and sets the word select (address bits 5:2) to the register number. It issues no bus access.
- R4: A write to register 16 pulses `bus_we` for exactly one cycle, in the cycle after the transaction. The address is {page, word select of the most recent low-register read or write, 2'b00} and the data is {register 16 data, pending lower half}.
- R5: A read of a low register sets the word select and pulses `bus_re` in the next cycle, at address {page, register number, 2'b00}. `bus_rdata` is sampled at the end of that cycle. Its bits 15:0 are returned on `mdio_rdata` with `mdio_rvalid` two cycles after the transaction.
- R6: A read of register 16 returns bits 31:16 of the word kept by the most recent low-register read, one cycle after the transaction, even if that address was written since. It issues no bus access.
- R7: Writes to registers 17 to 30 are ignored: no strobe, and page, word select and pending half are unchanged. Reads of registers 17 to 30 return 0 one cycle after the transaction.
- R8: Whenever `bus_we` or `bus_re` is high, bus address bits 1:0 are 0. `bus_we` and `bus_re` are never high together.
- R9: While `rst` is high and after it is released, `bus_we`, `bus_re` and `mdio_rvalid` are low and the page is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mdio_valid | input | 1 | One-cycle strobe of a decoded management transaction |
| mdio_write | input | 1 | 1 = write, 0 = read |
| mdio_phy | input | 5 | PHY address of the transaction |
| mdio_reg | input | 5 | Register number of the transaction |
| mdio_wdata | input | 16 | Write data |
| mdio_rdata | output | 16 | Read response data |
| mdio_rvalid | output | 1 | One-cycle strobe qualifying `mdio_rdata` |
| bus_addr | output | 16 | Internal byte address, bits 1:0 always 0 |
| bus_wdata | output | 32 | Internal write data |
| bus_we | output | 1 | Internal write strobe |
| bus_re | output | 1 | Internal read strobe; `bus_rdata` is sampled at the end of this cycle |
| bus_rdata | input | 32 | Internal read data |

## Verification
The page is loaded at zero, at a mid value with stray upper bits set, and at all ones. This separates correct page masking and placement from truncation or a shifted field. Word writes are issued with the word select taken from a low write and, separately, from a later low read. This shows whether the select follows the most recent low access or only low writes. Reads of words never written, and of words overwritten after being read, distinguish a kept upper half from a fresh fetch. Foreign PHY addresses and the unused registers 17 to 30 are mixed in, and each is followed by a page readback or a word write. This exposes any state those transactions disturb.

// File: rtl/mpb_pkg.sv
package mpb_pkg;

    localparam int HALF_W   = 16;
    localparam int WORD_W   = 2 * HALF_W;
    localparam int FIELD_W  = 5;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PAGE_WR,
        OP_PAGE_RD,
        OP_LOW_WR,
        OP_LOW_RD,
        OP_HIGH_WR,
        OP_HIGH_RD,
        OP_SPARE_RD
    } mpb_op_e;

    typedef struct packed {
        mpb_op_e             op;
        logic [HALF_W-1:0]   data;
    } mpb_cmd_t;

    function automatic logic is_read_op(input mpb_op_e op);
        return (op == OP_PAGE_RD) || (op == OP_HIGH_RD) || (op == OP_SPARE_RD);
    endfunction

endpackage

// File: rtl/mpb_decode.sv
module mpb_decode
    import mpb_pkg::*;
#(
    parameter int PHY_ADDR = 31,
    parameter int PAGE_REG = 31,
    parameter int HIGH_REG = 16,
    parameter int SEL_W    = 4
) (
    input  logic               valid,
    input  logic               write,
    input  logic [FIELD_W-1:0] phy,
    input  logic [FIELD_W-1:0] regnum,
    input  logic [HALF_W-1:0]  wdata,
    output mpb_cmd_t           cmd,
    output logic [SEL_W-1:0]   sel
);

    localparam int                 LOW_N    = 1 << SEL_W;
    localparam logic [FIELD_W-1:0] PHY_SEL  = FIELD_W'(PHY_ADDR);
    localparam logic [FIELD_W-1:0] PAGE_SEL = FIELD_W'(PAGE_REG);
    localparam logic [FIELD_W-1:0] HIGH_SEL = FIELD_W'(HIGH_REG);

    logic addressed;

    assign addressed = valid && (phy == PHY_SEL);
    assign sel       = regnum[SEL_W-1:0];

    always_comb begin
        cmd.op   = OP_IDLE;
        cmd.data = wdata;
        if (addressed) begin
            if (regnum == PAGE_SEL) begin
                cmd.op = write ? OP_PAGE_WR : OP_PAGE_RD;
            end else if (regnum == HIGH_SEL) begin
                cmd.op = write ? OP_HIGH_WR : OP_HIGH_RD;
            end else if (int'(regnum) < LOW_N) begin
                cmd.op = write ? OP_LOW_WR : OP_LOW_RD;
            end else if (!write) begin
                cmd.op = OP_SPARE_RD;
            end
        end
    end

endmodule

// File: rtl/mpb_page_state.sv
module mpb_page_state
    import mpb_pkg::*;
#(
    parameter int PAGE_W = 10,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  mpb_cmd_t          cmd,
    input  logic [SEL_W-1:0]  sel,
    output logic [PAGE_W-1:0] page,
    output logic [SEL_W-1:0]  wsel,
    output logic [HALF_W-1:0] low_hold
);

    always_ff @(posedge clk) begin
        if (rst) begin
            page     <= '0;
            wsel     <= '0;
            low_hold <= '0;
        end else begin
            case (cmd.op)
                OP_PAGE_WR: page <= cmd.data[PAGE_W-1:0];
                OP_LOW_WR: begin
                    wsel     <= sel;
                    low_hold <= cmd.data;
                end
                OP_LOW_RD: wsel <= sel;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mpb_bus_master.sv
module mpb_bus_master
    import mpb_pkg::*;
#(
    parameter int PAGE_W = 10,
    parameter int SEL_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  mpb_cmd_t                cmd,
    input  logic [SEL_W-1:0]        sel,
    input  logic [PAGE_W-1:0]       page,
    input  logic [SEL_W-1:0]        wsel,
    input  logic [HALF_W-1:0]       low_hold,
    input  logic [HALF_W-1:0]       rdata_hi,
    output logic [PAGE_W+SEL_W+1:0] bus_addr,
    output logic [WORD_W-1:0]       bus_wdata,
    output logic                    bus_we,
    output logic                    bus_re,
    output logic [HALF_W-1:0]       kept_hi
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_we    <= 1'b0;
            bus_re    <= 1'b0;
            kept_hi   <= '0;
        end else begin
            bus_we <= (cmd.op == OP_HIGH_WR);
            bus_re <= (cmd.op == OP_LOW_RD);
            if (cmd.op == OP_HIGH_WR) begin
                bus_addr  <= {page, wsel, 2'b00};
                bus_wdata <= {cmd.data, low_hold};
            end else if (cmd.op == OP_LOW_RD) begin
                bus_addr  <= {page, sel, 2'b00};
            end
            if (bus_re) begin
                kept_hi <= rdata_hi;
            end
        end
    end

endmodule

// File: rtl/mpb_responder.sv
module mpb_responder
    import mpb_pkg::*;
#(
    parameter int PAGE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  mpb_op_e           op,
    input  logic              fetch,
    input  logic [PAGE_W-1:0] page,
    input  logic [HALF_W-1:0] kept_hi,
    input  logic [HALF_W-1:0] rdata_lo,
    output logic [HALF_W-1:0] mdio_rdata,
    output logic              mdio_rvalid
);

    logic [HALF_W-1:0] page_ext;

    generate
        if (PAGE_W < HALF_W) begin : g_pad
            assign page_ext = {{(HALF_W - PAGE_W){1'b0}}, page};
        end else begin : g_trim
            assign page_ext = page[HALF_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            mdio_rdata  <= '0;
            mdio_rvalid <= 1'b0;
        end else begin
            mdio_rvalid <= fetch || is_read_op(op);
            if (fetch) begin
                mdio_rdata <= rdata_lo;
            end else begin
                case (op)
                    OP_PAGE_RD:  mdio_rdata <= page_ext;
                    OP_HIGH_RD:  mdio_rdata <= kept_hi;
                    OP_SPARE_RD: mdio_rdata <= '0;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
    import mpb_pkg::*;
#(
    parameter int PHY_ADDR = 31,
    parameter int PAGE_REG = 31,
    parameter int HIGH_REG = 16,
    parameter int PAGE_W   = 10,
    parameter int SEL_W    = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mdio_valid,
    input  logic                    mdio_write,
    input  logic [FIELD_W-1:0]      mdio_phy,
    input  logic [FIELD_W-1:0]      mdio_reg,
    input  logic [HALF_W-1:0]       mdio_wdata,
    output logic [HALF_W-1:0]       mdio_rdata,
    output logic                    mdio_rvalid,
    output logic [PAGE_W+SEL_W+1:0] bus_addr,
    output logic [WORD_W-1:0]       bus_wdata,
    output logic                    bus_we,
    output logic                    bus_re,
    input  logic [WORD_W-1:0]       bus_rdata
);

    mpb_cmd_t          cmd;
    logic [SEL_W-1:0]  sel;
    logic [PAGE_W-1:0] page;
    logic [SEL_W-1:0]  wsel;
    logic [HALF_W-1:0] low_hold;
    logic [HALF_W-1:0] kept_hi;

    mpb_decode #(
        .PHY_ADDR(PHY_ADDR),
        .PAGE_REG(PAGE_REG),
        .HIGH_REG(HIGH_REG),
        .SEL_W   (SEL_W)
    ) u_decode (
        .valid (mdio_valid),
        .write (mdio_write),
        .phy   (mdio_phy),
        .regnum(mdio_reg),
        .wdata (mdio_wdata),
        .cmd   (cmd),
        .sel   (sel)
    );

    mpb_page_state #(
        .PAGE_W(PAGE_W),
        .SEL_W (SEL_W)
    ) u_state (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .sel     (sel),
        .page    (page),
        .wsel    (wsel),
        .low_hold(low_hold)
    );

    mpb_bus_master #(
        .PAGE_W(PAGE_W),
        .SEL_W (SEL_W)
    ) u_bus (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .sel      (sel),
        .page     (page),
        .wsel     (wsel),
        .low_hold (low_hold),
        .rdata_hi (bus_rdata[WORD_W-1:HALF_W]),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we   (bus_we),
        .bus_re   (bus_re),
        .kept_hi  (kept_hi)
    );

    mpb_responder #(
        .PAGE_W(PAGE_W)
    ) u_resp (
        .clk        (clk),
        .rst        (rst),
        .op         (cmd.op),
        .fetch      (bus_re),
        .page       (page),
        .kept_hi    (kept_hi),
        .rdata_lo   (bus_rdata[HALF_W-1:0]),
        .mdio_rdata (mdio_rdata),
        .mdio_rvalid(mdio_rvalid)
    );

endmodule

// File: rtl/mpb_checker.sv
module mpb_checker #(
    parameter int PHY_ADDR = 31,
    parameter int PAGE_REG = 31,
    parameter int HIGH_REG = 16,
    parameter int SEL_W    = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              mdio_valid,
    input logic              mdio_write,
    input logic [4:0]        mdio_phy,
    input logic [4:0]        mdio_reg,
    input logic [15:0]       mdio_wdata,
    input logic [15:0]       mdio_rdata,
    input logic              mdio_rvalid,
    input logic [SEL_W+1:0]  bus_addr_lo,
    input logic [15:0]       bus_wdata_hi,
    input logic              bus_we,
    input logic              bus_re,
    input logic [15:0]       bus_rdata_lo
);

    localparam int LOW_N = 1 << SEL_W;

    logic hit;
    logic foreign;
    logic reg_high;
    logic reg_low;
    logic reg_spare;

    assign hit       = mdio_valid && (mdio_phy == 5'(PHY_ADDR));
    assign foreign   = mdio_valid && (mdio_phy != 5'(PHY_ADDR));
    assign reg_high  = (mdio_reg == 5'(HIGH_REG));
    assign reg_low   = (int'(mdio_reg) < LOW_N) && !reg_high && (mdio_reg != 5'(PAGE_REG));
    assign reg_spare = !reg_low && !reg_high && (mdio_reg != 5'(PAGE_REG));

    assert_foreign_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        foreign && !bus_re |=> !bus_we && !bus_re && !mdio_rvalid);

    assert_low_write_holds_R3: assert property (@(posedge clk) disable iff (rst)
        hit && mdio_write && reg_low |=> !bus_we && !bus_re);

    assert_high_write_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        hit && mdio_write && reg_high |=> bus_we && (bus_wdata_hi == $past(mdio_wdata)));

    assert_low_read_fetch_R5: assert property (@(posedge clk) disable iff (rst)
        hit && !mdio_write && reg_low |=> bus_re && (bus_addr_lo[SEL_W+1:2] == $past(mdio_reg[SEL_W-1:0])));

    assert_low_read_return_R5: assert property (@(posedge clk) disable iff (rst)
        bus_re |=> mdio_rvalid && (mdio_rdata == $past(bus_rdata_lo)));

    assert_high_read_local_R6: assert property (@(posedge clk) disable iff (rst)
        hit && !mdio_write && reg_high |=> !bus_we && !bus_re && mdio_rvalid);

    assert_spare_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        hit && reg_spare |=> !bus_we && !bus_re);

    assert_spare_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
        hit && !mdio_write && reg_spare && !bus_re |=> mdio_rvalid && (mdio_rdata == 16'h0000));

    assert_aligned_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_we || bus_re) |-> (bus_addr_lo[1:0] == 2'b00));

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bus_we, bus_re}));

    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> !bus_we && !bus_re && !mdio_rvalid);

endmodule

bind mdio_page_bridge mpb_checker #(
    .PHY_ADDR(PHY_ADDR),
    .PAGE_REG(PAGE_REG),
    .HIGH_REG(HIGH_REG),
    .SEL_W   (SEL_W)
) u_mpb_chk (
    .clk         (clk),
    .rst         (rst),
    .mdio_valid  (mdio_valid),
    .mdio_write  (mdio_write),
    .mdio_phy    (mdio_phy),
    .mdio_reg    (mdio_reg),
    .mdio_wdata  (mdio_wdata),
    .mdio_rdata  (mdio_rdata),
    .mdio_rvalid (mdio_rvalid),
    .bus_addr_lo (bus_addr[SEL_W+1:0]),
    .bus_wdata_hi(bus_wdata[31:16]),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .bus_rdata_lo(bus_rdata[15:0])
);

// File: tb/mdio_page_bridge_test.sv
module mdio_page_bridge_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mdio_valid = 1'b0;
    logic        mdio_write = 1'b0;
    logic [4:0]  mdio_phy = 5'd0;
    logic [4:0]  mdio_reg = 5'd0;
    logic [15:0] mdio_wdata = 16'h0;
    logic [15:0] mdio_rdata;
    logic        mdio_rvalid;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we;
    logic        bus_re;
    logic [31:0] bus_rdata = 32'hBAD0_0BAD;

    always #5 clk = ~clk;

    mdio_page_bridge uut (
        .clk        (clk),
        .rst        (rst),
        .mdio_valid (mdio_valid),
        .mdio_write (mdio_write),
        .mdio_phy   (mdio_phy),
        .mdio_reg   (mdio_reg),
        .mdio_wdata (mdio_wdata),
        .mdio_rdata (mdio_rdata),
        .mdio_rvalid(mdio_rvalid),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_re     (bus_re),
        .bus_rdata  (bus_rdata)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // expected activity per cycle (reference model output)
    bit          ex_we    [int];
    logic [15:0] ex_waddr [int];
    logic [31:0] ex_wdata [int];
    bit          ex_re    [int];
    logic [15:0] ex_raddr [int];
    bit          ex_rv    [int];
    logic [15:0] ex_rdata [int];
    string       ex_tag   [int];

    // internal register space seen by the bus
    logic [31:0] mem [logic [15:0]];

    // reference model state
    logic [9:0]  m_page = 10'd0;
    logic [3:0]  m_sel  = 4'd0;
    logic [15:0] m_low  = 16'h0;
    logic [15:0] m_keep = 16'h0;

    int vectors = 0;
    int miscompares = 0;
    bit bad;
    bit finished = 1'b0;

    function automatic logic [31:0] seed(input logic [15:0] a);
        return {a ^ 16'h5A5A, ~a};
    endfunction

    function automatic logic [31:0] lookup(input logic [15:0] a);
        if (mem.exists(a)) return mem[a];
        return seed(a);
    endfunction

    // bus responder
    always @(negedge clk) begin
        if (bus_we) mem[bus_addr] = bus_wdata;
        if (bus_re) bus_rdata <= lookup(bus_addr);
        else        bus_rdata <= 32'hBAD0_0BAD;
    end

    task automatic report(input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
        bad = 1'b1;
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        string t;
        bit    e;
        if (cyc >= 1 && !finished) begin
            vectors++;
            bad = 1'b0;
            t = ex_tag.exists(cyc) ? ex_tag[cyc] : "R9";
            e = ex_we.exists(cyc);
            if (bus_we !== e) report(t, "bus_we", 32'(bus_we), 32'(e));
            else if (e) begin
                if (bus_addr !== ex_waddr[cyc]) report(t, "write addr", 32'(bus_addr), 32'(ex_waddr[cyc]));
                if (bus_wdata !== ex_wdata[cyc]) report(t, "write data", bus_wdata, ex_wdata[cyc]);
            end
            e = ex_re.exists(cyc);
            if (bus_re !== e) report(t, "bus_re", 32'(bus_re), 32'(e));
            else if (e && bus_addr !== ex_raddr[cyc]) report(t, "read addr", 32'(bus_addr), 32'(ex_raddr[cyc]));
            e = ex_rv.exists(cyc);
            if (mdio_rvalid !== e) report(t, "mdio_rvalid", 32'(mdio_rvalid), 32'(e));
            else if (e && mdio_rdata !== ex_rdata[cyc]) report(t, "mdio_rdata", 32'(mdio_rdata), 32'(ex_rdata[cyc]));
            if ((bus_we || bus_re) && bus_addr[1:0] !== 2'b00) report("R8", "addr[1:0]", 32'(bus_addr[1:0]), 32'd0);
            if (bus_we && bus_re) report("R8", "we&re", 32'd1, 32'd0);
            if (bad) miscompares++;
        end
    end

    task automatic txn(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] d, input string tag);
        int          k;
        logic [31:0] w;
        @(negedge clk);
        k = cyc;
        mdio_valid = 1'b1;
        mdio_write = wr;
        mdio_phy   = phy;
        mdio_reg   = rg;
        mdio_wdata = d;
        if (phy == 5'd31) begin
            if (rg == 5'd31) begin
                if (wr) m_page = d[9:0];
                else begin
                    ex_rv[k+1] = 1'b1;
                    ex_rdata[k+1] = {6'b0, m_page};
                end
            end else if (rg == 5'd16) begin
                if (wr) begin
                    ex_we[k+1] = 1'b1;
                    ex_waddr[k+1] = {m_page, m_sel, 2'b00};
                    ex_wdata[k+1] = {d, m_low};
                end else begin
                    ex_rv[k+1] = 1'b1;
                    ex_rdata[k+1] = m_keep;
                end
            end else if (rg < 5'd16) begin
                m_sel = rg[3:0];
                if (wr) m_low = d;
                else begin
                    w = lookup({m_page, rg[3:0], 2'b00});
                    m_keep = w[31:16];
                    ex_re[k+1] = 1'b1;
                    ex_raddr[k+1] = {m_page, rg[3:0], 2'b00};
                    ex_rv[k+2] = 1'b1;
                    ex_rdata[k+2] = w[15:0];
                end
            end else if (!wr) begin
                ex_rv[k+1] = 1'b1;
                ex_rdata[k+1] = 16'h0;
            end
        end
        ex_tag[k+1] = tag;
        ex_tag[k+2] = tag;
        @(negedge clk);
        mdio_valid = 1'b0;
        mdio_wdata = ~d;
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL R9 watchdog expired actual=running expected=done");
        miscompares++;
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: page resets to zero
        txn(0, 5'd31, 5'd31, 16'h0, "R9");
        // R2: only ten page bits are kept
        txn(1, 5'd31, 5'd31, 16'hFDA5, "R2");
        txn(0, 5'd31, 5'd31, 16'h0, "R2");
        // R3 then R4: low half held, write fires on register 16
        txn(1, 5'd31, 5'd3, 16'hBEEF, "R3");
        txn(1, 5'd31, 5'd16, 16'hDEAD, "R4");
        // R5/R6: read back both halves
        txn(0, 5'd31, 5'd3, 16'h0, "R5");
        txn(0, 5'd31, 5'd16, 16'h0, "R6");
        txn(0, 5'd31, 5'd7, 16'h0, "R5");
        txn(0, 5'd31, 5'd16, 16'h0, "R6");
        // R1: foreign PHY addresses touch nothing
        txn(1, 5'd5, 5'd31, 16'h0003, "R1");
        txn(1, 5'd5, 5'd16, 16'h7777, "R1");
        txn(0, 5'd5, 5'd3, 16'h0, "R1");
        txn(1, 5'd30, 5'd2, 16'h9999, "R1");
        txn(0, 5'd31, 5'd31, 16'h0, "R1");
        // R7: registers 17..30 ignored, read as zero
        txn(1, 5'd31, 5'd20, 16'h1234, "R7");
        txn(1, 5'd31, 5'd17, 16'h4321, "R7");
        txn(0, 5'd31, 5'd20, 16'h0, "R7");
        txn(0, 5'd31, 5'd30, 16'h0, "R7");
        txn(1, 5'd31, 5'd16, 16'h4444, "R7");
        txn(0, 5'd31, 5'd31, 16'h0, "R7");
        // R4: select follows the most recent low access, including reads
        txn(1, 5'd31, 5'd2, 16'h1111, "R3");
        txn(0, 5'd31, 5'd9, 16'h0, "R5");
        txn(1, 5'd31, 5'd16, 16'h2222, "R4");
        txn(0, 5'd31, 5'd9, 16'h0, "R5");
        txn(0, 5'd31, 5'd16, 16'h0, "R6");
        // R2/R4: top page and top word select
        txn(1, 5'd31, 5'd31, 16'h03FF, "R2");
        txn(1, 5'd31, 5'd15, 16'hA5A5, "R4");
        txn(1, 5'd31, 5'd16, 16'h5A5A, "R4");
        txn(0, 5'd31, 5'd15, 16'h0, "R5");
        txn(0, 5'd31, 5'd16, 16'h0, "R6");
        // R2/R4: bottom page and word
        txn(1, 5'd31, 5'd31, 16'h0000, "R2");
        txn(1, 5'd31, 5'd0, 16'h0001, "R4");
        txn(1, 5'd31, 5'd16, 16'h8000, "R4");
        txn(0, 5'd31, 5'd0, 16'h0, "R5");
        // R6: kept half survives a later write to the same word
        txn(1, 5'd31, 5'd16, 16'hCAFE, "R6");
        txn(0, 5'd31, 5'd16, 16'h0, "R6");
        txn(0, 5'd31, 5'd0, 16'h0, "R5");
        txn(0, 5'd31, 5'd16, 16'h0, "R6");
        repeat (4) @(negedge clk);
        summary();
    end

endmodule